// File: doc/BRIEF.md
# Two-Dimensional Haar Packet Reconstructor

This block rebuilds a 4x4 tile of signed samples from the sixteen subband coefficients produced by a one-level, two-dimensional Haar packet split. Each coefficient word is sign-magnitude. The split works on rows and on columns, so the tile passes through two levels of the filter tree. The coefficients arrive one word per cycle on a valid/data interface. They come as four 2x2 subband matrices. Once all sixteen are held, two cascaded sum/difference stages invert the split, with holding registers between the stages. The first stage undoes the column split and the second undoes the row split.

Each inverse step maps a pair (L, H) to (L+H, L-H). The two stages together return four times the original value, so a two-bit arithmetic shift removes that gain. The sixteen rebuilt samples then leave in raster order. A pulse marks the last of them. A controller built around a 5-bit counter sequences the phases: load, column step, row step and emit.

Top module: `haar_pkt_recon`

## Requirements
- R1: While reset is high and in the cycle after it falls, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: A word is accepted at a rising clock edge where `in_valid` and `in_ready` are both 1. The sixteen words of a tile come in this order: the HH matrix, then HL, then LH, then LL. Each matrix is sent as element (1,1), (1,2), (2,1), (2,2).
- R3: Coefficient and sample words are sign-magnitude: bit 15 is the sign (1 = negative) and bits 14:0 are the magnitude. A coefficient of negative zero (0x8000) acts exactly like zero.
- R4: Take the quad of samples a=x(2i,2j), b=x(2i,2j+1), c=x(2i+1,2j), d=x(2i+1,2j+1), counted from 0. Its coefficients at element (i,j) are LL=a+b+c+d, LH=(a-b)+(c-d), HL=(a+b)-(c+d) and HH=(a-b)-(c-d). From these, the block outputs a, b, c and d exactly, for any samples with |x| <= 8191.
- R5: The sixteen samples leave on sixteen consecutive cycles with `out_valid` high. They go row by row, left to right, from element (1,1) to element (4,4).
- R6: `out_valid` first rises at the second rising edge after the edge that accepts the sixteenth coefficient.
- R7: `out_last` is high for exactly one cycle, together with the sixteenth sample, and low otherwise.
- R8: `in_ready` is 0 from the edge that accepts the sixteenth coefficient until the edge that ends the `out_last` cycle. Words offered during that window are ignored. `in_ready` is 1 again right after the last sample.
- R9: The gain of 4 from the two stages is removed by a 2-bit arithmetic right shift. A zero sample always leaves as 0x0000, never as negative zero.
- R10: Idle cycles (`in_valid` low) between coefficients of a tile are allowed. Data presented during them is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Coefficient word present |
| in_coef | input | 16 | Sign-magnitude coefficient |
| in_ready | output | 1 | Block is in its load phase and accepts words |
| out_valid | output | 1 | Rebuilt sample present |
| out_sample | output | 16 | Sign-magnitude rebuilt sample |
| out_last | output | 1 | Marks the sixteenth sample of a tile |

## Verification
A fault in the counter or in the phase sequence shows up within a tile. The first sample arrives one cycle early or late, or the burst is broken, or `out_last` lands on the wrong sample. A word that slips past the load gate shows up in the tile that follows. A fault in a butterfly or in the coefficient store corrupts the samples of one quad. Those are four fixed raster positions, so the affected outputs point to the subband element involved. A sign-handling fault shows up only on tiles with negative values or negative-zero coefficients. For that reason, both kinds of tile are driven in the bench.

// File: rtl/haar_rc_pkg.sv
package haar_rc_pkg;

    localparam int COEF_W     = 16;
    localparam int ACC_W      = COEF_W + 2;
    localparam int GAIN_SHIFT = 2;
    localparam int TILE_N     = 16;
    localparam int QUADS      = 4;
    localparam int IDX_W      = $clog2(TILE_N);

    localparam int BAND_HH = 0;
    localparam int BAND_HL = 1;
    localparam int BAND_LH = 2;
    localparam int BAND_LL = 3;

    typedef logic [COEF_W-1:0]       smword_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        PH_LOAD,
        PH_COLS,
        PH_ROWS,
        PH_EMIT
    } phase_e;

    typedef struct packed {
        acc_t ll;
        acc_t lh;
        acc_t hl;
        acc_t hh;
    } quad_coef_t;

    typedef struct packed {
        acc_t p00;
        acc_t p01;
        acc_t p10;
        acc_t p11;
    } quad_smp_t;

    function automatic acc_t sm_to_acc(smword_t w);
        acc_t mag;
        mag = acc_t'({{(ACC_W-COEF_W+1){1'b0}}, w[COEF_W-2:0]});
        return w[COEF_W-1] ? -mag : mag;
    endfunction

    function automatic smword_t acc_to_sm(acc_t v);
        acc_t mag;
        mag = v[ACC_W-1] ? -v : v;
        return {v[ACC_W-1], mag[COEF_W-2:0]};
    endfunction

endpackage

// File: rtl/haar_rc_bfly.sv
module haar_rc_bfly
    import haar_rc_pkg::*;
(
    input  acc_t lo,
    input  acc_t hi,
    output acc_t sum,
    output acc_t dif
);
    assign sum = lo + hi;
    assign dif = lo - hi;
endmodule

// File: rtl/haar_rc_ctrl.sv
module haar_rc_ctrl
    import haar_rc_pkg::*;
#(
    parameter int NWORDS = TILE_N,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             ld_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             lat_cols,
    output logic             lat_rows,
    output logic             emit,
    output logic [IDX_W-1:0] emit_idx,
    output logic             last
);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(NWORDS - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LOAD;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_LOAD: if (in_valid) begin
                    if (cnt == CNT_END) begin
                        phase <= PH_COLS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_COLS: phase <= PH_ROWS;
                PH_ROWS: begin
                    phase <= PH_EMIT;
                    cnt   <= '0;
                end
                PH_EMIT: begin
                    if (cnt == CNT_END) begin
                        phase <= PH_LOAD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    assign ld_ready = (phase == PH_LOAD);
    assign wr_en    = ld_ready && in_valid;
    assign wr_idx   = cnt[IDX_W-1:0];
    assign lat_cols = (phase == PH_COLS);
    assign lat_rows = (phase == PH_ROWS);
    assign emit     = (phase == PH_EMIT);
    assign emit_idx = cnt[IDX_W-1:0];
    assign last     = emit && (cnt == CNT_END);

    // R5: once started, a burst continues until its last sample
    assert_burst_contig_R5: assert property (@(posedge clk) disable iff (rst)
        (emit && !last) |=> emit);

    // R8: load phase resumes right after the last sample
    assert_reload_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        last |=> (ld_ready && !emit));

    // R6: emission starts only after the row stage latched
    assert_emit_after_rows_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(emit) |-> $past(lat_rows));

endmodule

// File: rtl/haar_rc_quad.sv
module haar_rc_quad
    import haar_rc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lat_cols,
    input  logic       lat_rows,
    input  quad_coef_t cf,
    output quad_smp_t  smp
);
    acc_t sl_d, dl_d, sh_d, dh_d;
    acc_t sl_q, dl_q, sh_q, dh_q;
    acc_t a_d, b_d, c_d, d_d;

    // column step: undo the vertical split
    haar_rc_bfly u_col_l (.lo(cf.ll), .hi(cf.hl), .sum(sl_d), .dif(dl_d));
    haar_rc_bfly u_col_h (.lo(cf.lh), .hi(cf.hh), .sum(sh_d), .dif(dh_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            sl_q <= '0;
            dl_q <= '0;
            sh_q <= '0;
            dh_q <= '0;
        end else if (lat_cols) begin
            sl_q <= sl_d;
            dl_q <= dl_d;
            sh_q <= sh_d;
            dh_q <= dh_d;
        end
    end

    // row step: undo the horizontal split
    haar_rc_bfly u_row_t (.lo(sl_q), .hi(sh_q), .sum(a_d), .dif(b_d));
    haar_rc_bfly u_row_b (.lo(dl_q), .hi(dh_q), .sum(c_d), .dif(d_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else if (lat_rows) begin
            smp.p00 <= a_d;
            smp.p01 <= b_d;
            smp.p10 <= c_d;
            smp.p11 <= d_d;
        end
    end

    // R6: row stage only ever follows the column stage
    assert_row_after_col_R6: assert property (@(posedge clk) disable iff (rst)
        lat_rows |-> $past(lat_cols));

endmodule

// File: rtl/haar_pkt_recon.sv
module haar_pkt_recon
    import haar_rc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_coef,
    output logic        in_ready,
    output logic        out_valid,
    output logic [15:0] out_sample,
    output logic        out_last
);
    logic             wr_en, lat_cols, lat_rows, emit, last;
    logic [IDX_W-1:0] wr_idx, emit_idx;

    logic [TILE_N-1:0][COEF_W-1:0] store_q;
    quad_smp_t                     smp [QUADS];

    haar_rc_ctrl #(.NWORDS(TILE_N), .CNT_W(5)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .ld_ready (in_ready),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .lat_cols (lat_cols),
        .lat_rows (lat_rows),
        .emit     (emit),
        .emit_idx (emit_idx),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (wr_en) begin
            store_q[wr_idx] <= in_coef;
        end
    end

    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        quad_coef_t cf;
        always_comb begin
            cf.hh = sm_to_acc(store_q[BAND_HH*QUADS + q]);
            cf.hl = sm_to_acc(store_q[BAND_HL*QUADS + q]);
            cf.lh = sm_to_acc(store_q[BAND_LH*QUADS + q]);
            cf.ll = sm_to_acc(store_q[BAND_LL*QUADS + q]);
        end
        haar_rc_quad u_quad (
            .clk      (clk),
            .rst      (rst),
            .lat_cols (lat_cols),
            .lat_rows (lat_rows),
            .cf       (cf),
            .smp      (smp[q])
        );
    end

    // raster index -> quad {row[1], col[1]}, position {row[0], col[0]}
    logic [1:0] sel_q, sel_p;
    acc_t       sel_v, shifted;

    assign sel_q = {emit_idx[3], emit_idx[1]};
    assign sel_p = {emit_idx[2], emit_idx[0]};

    always_comb begin
        unique case (sel_p)
            2'd0:    sel_v = smp[sel_q].p00;
            2'd1:    sel_v = smp[sel_q].p01;
            2'd2:    sel_v = smp[sel_q].p10;
            default: sel_v = smp[sel_q].p11;
        endcase
    end

    assign shifted    = sel_v >>> GAIN_SHIFT;
    assign out_valid  = emit;
    assign out_last   = last;
    assign out_sample = emit ? acc_to_sm(shifted) : '0;

    // R8: stored coefficients stay put outside the load phase
    assert_store_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(store_q));

    // R9: a valid sample is never negative zero
    assert_no_neg_zero_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sample != {1'b1, {(COEF_W-1){1'b0}}}));

    // R7: the last marker only appears with a valid sample
    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

endmodule

// File: tb/test_haar_pkt_recon.sv
module test_haar_pkt_recon;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_coef = '0;
    logic        in_ready, out_valid, out_last;
    logic [15:0] out_sample;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    haar_pkt_recon i_haar_pkt_recon (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_coef    (in_coef),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_last   (out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] to_sm(input int v, input bit negz);
        if (v < 0)       return {1'b1, 15'(-v)};
        else if (v == 0) return negz ? 16'h8000 : 16'h0000;
        else             return {1'b0, 15'(v)};
    endfunction

    // forward split per R4; coefficient index = band*4 + i*2 + j, bands HH,HL,LH,LL
    task automatic split(input int x[16], input bit negz, output logic [15:0] c[16]);
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 2; j++) begin
                int a, b, cc, d, q;
                a  = x[(2*i)*4 + 2*j];
                b  = x[(2*i)*4 + 2*j + 1];
                cc = x[(2*i+1)*4 + 2*j];
                d  = x[(2*i+1)*4 + 2*j + 1];
                q  = i*2 + j;
                c[0*4+q] = to_sm((a-b)-(cc-d), negz);
                c[1*4+q] = to_sm((a+b)-(cc+d), negz);
                c[2*4+q] = to_sm((a-b)+(cc-d), negz);
                c[3*4+q] = to_sm(a+b+cc+d, negz);
            end
        end
    endtask

    task automatic run_tile(input int x[16], input bit gaps, input bit junk,
                            input bit negz);
        logic [15:0] c[16];
        split(x, negz, c);
        for (int k = 0; k < 16; k++) begin
            if (gaps && (k % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_coef  = 16'h7FFF;
                @(negedge clk);
                chk(in_ready == 1'b1, "R10", "ready during gap", int'(in_ready), 1);
            end else begin
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_coef  = c[k];
        end
        @(negedge clk);
        in_valid = junk;
        in_coef  = 16'h4321;
        chk(in_ready == 1'b0, "R8", "ready after 16th word", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R6", "valid too early (1)", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6", "valid too early (2)", int'(out_valid), 0);
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            if (junk) in_coef = 16'(16'h1111 * n + 16'h0F0F);
            chk(out_valid == 1'b1, "R5", $sformatf("valid at sample %0d", n),
                int'(out_valid), 1);
            chk(out_sample == to_sm(x[n], 1'b0), "R4",
                $sformatf("sample %0d word", n), int'(out_sample),
                int'(to_sm(x[n], 1'b0)));
            chk(out_last == (n == 15), "R7", $sformatf("last at sample %0d", n),
                int'(out_last), int'(n == 15));
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b1, "R8", "ready after burst", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R5", "valid after burst", int'(out_valid), 0);
        chk(out_last == 1'b0, "R7", "last after burst", int'(out_last), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "ready in reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_last == 1'b0, "R1", "last after reset", int'(out_last), 0);
        chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_directed();   // R2 R4 R5 R6 R7
        int x[16] = '{3, -1, 0, 2, 5, 5, -4, 1, 0, -2, 7, -7, 1, 1, 1, -3};
        run_tile(x, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_gaps();       // R10
        int x[16] = '{-6, 4, 9, 9, 0, 0, -1, 12, 30, -30, 2, 8, -5, -5, 6, 0};
        run_tile(x, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_busy_words(); // R8: words during compute/emit ignored
        int x[16] = '{10, 20, 30, 40, -10, -20, -30, -40, 1, 2, 3, 4, 5, 6, 7, 8};
        int y[16] = '{0, 1, 0, 1, 1, 0, 1, 0, -2, -2, 2, 2, 9, -9, 9, -9};
        run_tile(x, 1'b0, 1'b1, 1'b0);
        run_tile(y, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_neg_zero();   // R3 R9
        int z[16];
        int f[16];
        for (int k = 0; k < 16; k++) begin
            z[k] = 0;
            f[k] = 5;
        end
        run_tile(z, 1'b0, 1'b0, 1'b1);
        run_tile(f, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_extremes();   // R4 R9 full range
        int x[16];
        for (int k = 0; k < 16; k++) x[k] = ((k + k/4) % 2 == 0) ? 8191 : -8191;
        run_tile(x, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 16; k++) x[k] = (k < 8) ? -8191 : 8191;
        run_tile(x, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_random();     // R4 R5
        int x[16];
        for (int t = 0; t < 6; t++) begin
            for (int k = 0; k < 16; k++) x[k] = int'($urandom_range(16382, 0)) - 8191;
            run_tile(x, (t % 2) == 1, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_directed();
        t_gaps();
        t_busy_words();
        t_neg_zero();
        t_extremes();
        t_random();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule